// File: doc/BRIEF.md
# Coordinated SoC and Boot Flash Reset Sequencer

This block sits between the board's reset sources, an SoC and the SPI flash that the SoC boots from. Some flash parts keep upper-address state across an SoC reset. If that state is not cleared, the SoC's boot code looks in the wrong part of the flash. On every reset event the sequencer holds the SoC in reset and resets the flash. It then waits a programmable recovery time and releases the SoC in a legal order, so that boot always begins with the flash in its default state.

Three kinds of event start a sequence:
- a cold (power-on) input;
- a warm input, which is the OR of every warm source on the board, a debugger reset line included;
- a firmware status pin. The board pulls this pin weakly low, and boot firmware drives it high. When the pin falls back to low, the SoC has reset itself internally without showing it on any other pin.

Two configuration inputs choose the methods:
- one selects how the flash is reset: by pulsing its reset pin or by cutting its supply enable;
- the other selects whether a warm event holds the SoC through the warm reset output only, or through the cold reset output as well.

Top module: `flash_boot_reset_seq`

## Requirements
- R1: While `por_in_n` is low, `soc_cold_rst_n` and `soc_warm_rst_n` are low at once, without waiting for a clock. The flash reset is active during this time. After `por_in_n` rises, two clocks of reset synchronisation pass, then the flash reset stays active for `PULSE_CYC` more cycles.
- R2: `srst_in_n` low passes through a two-flop synchronizer and starts a sequence. The flash reset stays active while the synchronized input is low and for `PULSE_CYC` cycles after its last low sample. A single-cycle low gives exactly `PULSE_CYC` active cycles.
- R3: When `cfg_pwr_mode` is 1, the flash is reset by driving `flash_pwr_en` low and `flash_rst_n` stays high. When it is 0, `flash_rst_n` is driven low and `flash_pwr_en` stays high. The two are never active together.
- R4: After the flash reset is released, the SoC stays held for a full `RECOV_CYC` cycles before any SoC reset output is released. The time after release is never counted as part of this recovery time.
- R5: When `cfg_hold_cold` is 1, a warm or status event also drives `soc_cold_rst_n` low. When it is 0, such an event drives only `soc_warm_rst_n` low. A cold input always drives both low.
- R6: `soc_cold_rst_n` is never low while `soc_warm_rst_n` is high. When both were held, `soc_cold_rst_n` is released first and `soc_warm_rst_n` follows exactly `GAP_CYC` cycles later.
- R7: `fw_status` is synchronized and then filtered, so a level change is accepted only after `FILT_CYC` consecutive differing samples. After an accepted rise to high while idle, an accepted fall to low starts a sequence as a warm event. A shorter glitch has no effect.
- R8: A `fw_status` fall is ignored in two cases: while a sequence is in progress, and after the last sequence until the pin has again been accepted high while idle.
- R9: A new warm or cold input during a sequence restarts it from the flash reset phase with full counts. A cold input at any point drives both SoC outputs low again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running sequencer clock |
| por_in_n | input | 1 | Cold reset input, active low, asynchronous |
| srst_in_n | input | 1 | Combined warm reset input, active low, asynchronous |
| fw_status | input | 1 | Firmware status pin; pulled low, driven high after boot |
| cfg_pwr_mode | input | 1 | 1: reset flash by its supply enable; 0: by its reset pin |
| cfg_hold_cold | input | 1 | 1: warm events also hold the SoC through the cold output |
| soc_cold_rst_n | output | 1 | SoC cold reset, active low |
| soc_warm_rst_n | output | 1 | SoC warm reset, active low |
| flash_rst_n | output | 1 | Flash reset pin, active low |
| flash_pwr_en | output | 1 | Flash supply enable, low removes power |

## Verification
The sequence is started from each source in turn: cold input, a single-cycle warm pulse, a warm input held for several cycles, and a status-pin fall. Each run measures the lengths of the flash, recovery and release-gap windows. Comparing a one-cycle pulse with a held pulse separates reloading the count from merely starting it. Running the same pulse in both configurations separates the two flash methods and the two SoC hold methods. Status glitches shorter than the filter, falls during a sequence, and falls before the pin is re-armed each show whether the status path is gated correctly. A second warm pulse during recovery and a cold pulse during the release gap exercise the restart path and the release order.

// File: rtl/flash_boot_reset_seq.sv
module flash_boot_reset_seq #(
  parameter int PULSE_CYC = 8,
  parameter int RECOV_CYC = 20,
  parameter int GAP_CYC   = 4,
  parameter int FILT_CYC  = 3
) (
  input  logic clk,
  input  logic por_in_n,
  input  logic srst_in_n,
  input  logic fw_status,
  input  logic cfg_pwr_mode,
  input  logic cfg_hold_cold,
  output logic soc_cold_rst_n,
  output logic soc_warm_rst_n,
  output logic flash_rst_n,
  output logic flash_pwr_en
);

  localparam int M1   = (PULSE_CYC > RECOV_CYC) ? PULSE_CYC : RECOV_CYC;
  localparam int MAXC = (M1 > GAP_CYC) ? M1 : GAP_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam int FW   = $clog2(FILT_CYC + 1);

  typedef enum logic [1:0] {S_RUN, S_FLASH, S_RECOV, S_GAP} phase_t;

  logic [1:0]    rs;
  logic          rst_n;
  logic [1:0]    ws, ts;
  logic          flt;
  logic [FW-1:0] fcnt;
  logic          armed;
  logic          cold_act;
  phase_t        st;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge por_in_n)
    if (!por_in_n) rs <= '0;
    else           rs <= {rs[0], 1'b1};

  assign rst_n = rs[1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ws <= 2'b11;
      ts <= 2'b00;
    end else begin
      ws <= {ws[0], srst_in_n};
      ts <= {ts[0], fw_status};
    end

  wire differ  = ts[1] != flt;
  wire accept  = differ && (fcnt == FW'(FILT_CYC - 1));
  wire fall_ev = accept && flt;
  wire rise_ev = accept && !flt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      flt  <= 1'b0;
      fcnt <= '0;
    end else if (accept) begin
      flt  <= ts[1];
      fcnt <= '0;
    end else if (differ) begin
      fcnt <= fcnt + 1'b1;
    end else begin
      fcnt <= '0;
    end

  wire idle  = st == S_RUN;
  wire start = !ws[1] || (fall_ev && armed && idle);
  wire last  = cnt == '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                  armed <= 1'b0;
    else if (start || fall_ev)   armed <= 1'b0;
    else if (rise_ev && idle)    armed <= 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st       <= S_FLASH;
      cnt      <= CW'(PULSE_CYC - 1);
      cold_act <= 1'b1;
    end else if (start) begin
      st       <= S_FLASH;
      cnt      <= CW'(PULSE_CYC - 1);
      cold_act <= cold_act | cfg_hold_cold;
    end else begin
      case (st)
        S_FLASH:
          if (last) begin
            st  <= S_RECOV;
            cnt <= CW'(RECOV_CYC - 1);
          end else cnt <= cnt - 1'b1;
        S_RECOV:
          if (last && cold_act) begin
            st  <= S_GAP;
            cnt <= CW'(GAP_CYC - 1);
          end else if (last) begin
            st <= S_RUN;
          end else cnt <= cnt - 1'b1;
        S_GAP:
          if (last) begin
            st       <= S_RUN;
            cold_act <= 1'b0;
          end else cnt <= cnt - 1'b1;
        default: ;
      endcase
    end

  wire flash_phase = st == S_FLASH;
  wire hold_phase  = flash_phase || st == S_RECOV;

  assign soc_cold_rst_n = !(cold_act && hold_phase);
  assign soc_warm_rst_n = idle;
  assign flash_rst_n    = !(flash_phase && !cfg_pwr_mode);
  assign flash_pwr_en   = !(flash_phase && cfg_pwr_mode);

endmodule

// File: rtl/flash_boot_reset_seq_chk.sv
module flash_boot_reset_seq_chk #(
  parameter int RECOV_CYC = 20
) (
  input logic clk,
  input logic por_in_n,
  input logic srst_in_n,
  input logic soc_cold_rst_n,
  input logic soc_warm_rst_n,
  input logic flash_rst_n,
  input logic flash_pwr_en
);

  int rec;
  int age;

  always_ff @(posedge clk or negedge por_in_n)
    if (!por_in_n) begin
      rec <= 0;
      age <= 0;
    end else begin
      if (age < 8) age <= age + 1;
      if (!flash_rst_n || !flash_pwr_en) rec <= 0;
      else if (rec < RECOV_CYC)          rec <= rec + 1;
    end

  AST_METHOD_EXCLUSIVE: assert property (@(posedge clk) disable iff (!por_in_n)
    !(!flash_rst_n && !flash_pwr_en)); // R3
  AST_FLASH_UNDER_HOLD: assert property (@(posedge clk) disable iff (!por_in_n)
    (!flash_rst_n || !flash_pwr_en) |-> !soc_warm_rst_n); // R1
  AST_COLD_WITH_WARM: assert property (@(posedge clk) disable iff (!por_in_n)
    !soc_cold_rst_n |-> !soc_warm_rst_n); // R6
  AST_WARM_LAGS_COLD: assert property (@(posedge clk) disable iff (!por_in_n)
    $rose(soc_cold_rst_n) |-> !soc_warm_rst_n); // R6
  AST_WARM_FULL_RECOV: assert property (@(posedge clk) disable iff (!por_in_n)
    $rose(soc_warm_rst_n) |-> rec >= RECOV_CYC); // R4
  AST_COLD_FULL_RECOV: assert property (@(posedge clk) disable iff (!por_in_n)
    $rose(soc_cold_rst_n) |-> rec >= RECOV_CYC); // R4
  AST_WARM_IN_HOLDS: assert property (@(posedge clk) disable iff (!por_in_n)
    (age >= 6 && $past(!srst_in_n, 3)) |-> !soc_warm_rst_n); // R2

endmodule

bind flash_boot_reset_seq flash_boot_reset_seq_chk #(.RECOV_CYC(RECOV_CYC)) u_chk (
  .clk(clk),
  .por_in_n(por_in_n),
  .srst_in_n(srst_in_n),
  .soc_cold_rst_n(soc_cold_rst_n),
  .soc_warm_rst_n(soc_warm_rst_n),
  .flash_rst_n(flash_rst_n),
  .flash_pwr_en(flash_pwr_en)
);

// File: tb/tb_flash_boot_reset_seq.sv
module tb_flash_boot_reset_seq;
  localparam int PULSE = 8, RECOV = 20, GAP = 4, FILT = 3;

  logic clk = 0;
  always #5 clk = ~clk;

  logic por_n = 1, srst_n = 1, fws = 0, cpwr = 0, ccold = 0;
  logic cold_n, warm_n, frst_n, fpwr;

  flash_boot_reset_seq #(.PULSE_CYC(PULSE), .RECOV_CYC(RECOV), .GAP_CYC(GAP), .FILT_CYC(FILT)) dut (
    .clk(clk), .por_in_n(por_n), .srst_in_n(srst_n), .fw_status(fws),
    .cfg_pwr_mode(cpwr), .cfg_hold_cold(ccold),
    .soc_cold_rst_n(cold_n), .soc_warm_rst_n(warm_n),
    .flash_rst_n(frst_n), .flash_pwr_en(fpwr));

  int total = 0, bad = 0, cyc = 0;
  bit go = 0, done = 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // reference model: phase 0 idle, 1 flash, 2 recovery, 3 release gap
  int mrs, ph, rem, mcold, s0, s1, t0, t1, flt, run, armed;

  task automatic mreset();
    ph = 1; rem = PULSE; mcold = 1; s0 = 1; s1 = 1; t0 = 0; t1 = 0;
    flt = 0; run = 0; armed = 0;
  endtask

  task automatic mstep();
    bit differ, acc, fall, rise, start;
    differ = t1 != flt;
    acc    = differ && (run + 1 == FILT);
    fall   = acc && flt == 1;
    rise   = acc && flt == 0;
    if (acc) begin run = 0; flt = t1; end
    else if (differ) run = run + 1;
    else run = 0;
    start = (s1 == 0) || (fall && armed == 1 && ph == 0);
    if (start || fall) armed = 0;
    else if (rise && ph == 0) armed = 1;
    if (start) begin
      mcold = mcold | int'(ccold); ph = 1; rem = PULSE;
    end else if (ph != 0) begin
      if (rem > 1) rem--;
      else if (ph == 1) begin ph = 2; rem = RECOV; end
      else if (ph == 2 && mcold == 1) begin ph = 3; rem = GAP; end
      else begin ph = 0; mcold = 0; end
    end
    s1 = s0; s0 = int'(srst_n); t1 = t0; t0 = int'(fws);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!por_n) begin mrs = 0; mreset(); end
    else if (mrs < 2) begin mreset(); mrs++; end
    else mstep();
    if (cyc > 100000 && !done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=0", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  always @(negedge clk) if (go && !done) begin
    chk(cold_n == !(mcold == 1 && (ph == 1 || ph == 2)), "R5 model soc_cold_rst_n", int'(cold_n), int'(!(mcold == 1 && (ph == 1 || ph == 2))));
    chk(warm_n == (ph == 0), "R4 model soc_warm_rst_n", int'(warm_n), int'(ph == 0));
    chk(frst_n == !(ph == 1 && !cpwr), "R3 model flash_rst_n", int'(frst_n), int'(!(ph == 1 && !cpwr)));
    chk(fpwr == !(ph == 1 && cpwr), "R3 model flash_pwr_en", int'(fpwr), int'(!(ph == 1 && cpwr)));
  end

  task automatic tick(int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  int m_nf, m_nfr, m_nc, m_nw, m_ep;
  task automatic measure(int n);
    bit prev = 0, act;
    m_nf = 0; m_nfr = 0; m_nc = 0; m_nw = 0; m_ep = 0;
    repeat (n) begin
      @(negedge clk);
      act = !frst_n || !fpwr;
      if (act) m_nf++;
      if (!frst_n) m_nfr++;
      if (act && !prev) m_ep++;
      if (!act && !cold_n) m_nc++;
      if (!act && !warm_n) m_nw++;
      prev = act;
    end
    #1;
  endtask

  task automatic warm_pulse();
    srst_n = 0; tick(1); srst_n = 1;
  endtask

  initial begin
    #1 por_n = 0;
    @(posedge clk);
    go = 1;
    tick(3);
    chk(cold_n == 0, "R1 cold held in por", int'(cold_n), 0);
    chk(warm_n == 0, "R1 warm held in por", int'(warm_n), 0);
    chk(frst_n == 0 && fpwr == 1, "R1 flash reset in por", int'(frst_n), 0);
    por_n = 1;
    measure(80);
    chk(m_nf == PULSE + 1, "R1 flash window after por", m_nf, PULSE + 1);
    chk(m_nc == RECOV, "R4 cold recovery after por", m_nc, RECOV);
    chk(m_nw == RECOV + GAP, "R6 warm gap after por", m_nw, RECOV + GAP);

    warm_pulse();
    measure(60);
    chk(m_nf == PULSE, "R2 single pulse flash window", m_nf, PULSE);
    chk(m_nw == RECOV, "R4 warm recovery", m_nw, RECOV);
    chk(m_nc == 0, "R5 cold untouched in warm mode", m_nc, 0);

    ccold = 1; cpwr = 1; tick(2);
    warm_pulse();
    measure(60);
    chk(m_nf == PULSE && m_nfr == 0, "R3 power rail method", m_nfr, 0);
    chk(m_nc == RECOV, "R5 cold held in cold mode", m_nc, RECOV);
    chk(m_nw == RECOV + GAP, "R6 warm released after gap", m_nw, RECOV + GAP);
    ccold = 0; cpwr = 0; tick(2);

    fork
      begin srst_n = 0; tick(6); srst_n = 1; end
      measure(80);
    join
    chk(m_nf == PULSE + 5, "R2 held input reloads", m_nf, PULSE + 5);

    fws = 1; tick(10);
    chk(warm_n == 1, "R7 rise does not reset", int'(warm_n), 1);
    fws = 0;
    measure(60);
    chk(m_nf == PULSE, "R7 status fall flash window", m_nf, PULSE);
    chk(m_nw == RECOV, "R7 status fall recovery", m_nw, RECOV);

    fws = 1; tick(10);
    fws = 0; tick(FILT - 1); fws = 1;
    measure(40);
    chk(m_nf == 0, "R7 short glitch filtered", m_nf, 0);

    fork
      begin warm_pulse(); tick(5); fws = 0; end
      measure(80);
    join
    chk(m_ep == 1 && m_nf == PULSE, "R8 status fall in sequence ignored", m_nf, PULSE);
    chk(m_nw == RECOV, "R8 recovery not extended", m_nw, RECOV);
    fws = 1; tick(1); fws = 0;
    measure(40);
    chk(m_nf == 0 && m_nw == 0, "R8 unarmed fall ignored", m_nf, 0);

    fork
      begin warm_pulse(); tick(15); warm_pulse(); end
      measure(100);
    join
    chk(m_ep == 2, "R9 flash reset again on restart", m_ep, 2);
    chk(m_nf == 2 * PULSE, "R9 full pulse on restart", m_nf, 2 * PULSE);

    ccold = 1; tick(2);
    warm_pulse();
    tick(PULSE + RECOV + 2);
    chk(cold_n == 1 && warm_n == 0, "R6 in release gap", int'(cold_n), 1);
    por_n = 0; #1;
    chk(cold_n == 0 && warm_n == 0, "R9 cold input in gap reasserts", int'(cold_n), 0);
    tick(2); por_n = 1;
    measure(80);
    chk(m_nc == RECOV && m_nw == RECOV + GAP, "R9 restart from cold", m_nw, RECOV + GAP);
    chk(m_nf == PULSE + 1, "R9 flash window after cold restart", m_nf, PULSE + 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule